// File: doc/BRIEF.md
# Priority Fast-Switch Video Overlay Mixer

This block chooses, for every output sample, one of four pixel streams sharing one pixel clock: a composite stream, a component stream, an analog-RGB path and a 3-bit digital overlay colour. The choice comes from two fast-switch inputs, one for the analog-RGB path and one for the digital overlay. An 8-bit control word sets the switching mode, the polarity of each switch and the clock edge on which each switch is captured. Eight modes are provided. They range from fixed single-source output, through simple two-way overlays, to three modes in which one switch overrides the other.

Control words are written on a parallel port. A write is held in a pending copy and becomes active only at a frame-start strobe, so a mode change can never land in the middle of a line. A format input states whether the narrow output format is in use. Digital overlay may only be chosen in that format. In the wide format, any overlay choice falls back to the video source underneath it. The chosen pixel and a 2-bit source identifier leave the block from the same register.

Top module: `fsw_overlay_mixer`

## Requirements
- R1: While reset is high and after it is released, `pix_out` is 0 and `src_id` is 0. The active control word resets to 0xCC, which is composite-only with both switches captured on the falling edge and both polarities 0.
- R2: A pixel and switch value held through one clock cycle appear at the outputs just after the second rising edge that follows it. Both edge settings give this same latency.
- R3: Control word fields are: [7:5] mode, [4] unused, [3] overlay-switch edge, [2] RGB-switch edge, [1] overlay-switch polarity, [0] RGB-switch polarity. A write on `ctrl_wr_en` takes effect only at the next `frame_start` pulse.
- R4: In mode 000 the RGB switch selects the analog-RGB path when active and composite otherwise.
- R5: In mode 001 the overlay switch selects the overlay when active and composite otherwise. Mode 010 behaves the same way, with component as the base source.
- R6: In mode 011 an active overlay switch selects the overlay, whatever the RGB switch is. Otherwise the RGB switch chooses between analog-RGB and composite.
- R7: In mode 100 an active RGB switch selects analog-RGB. Otherwise the overlay switch chooses between overlay and composite.
- R8: In mode 101 an inactive RGB switch selects composite. Otherwise the overlay switch chooses between overlay and analog-RGB.
- R9: Mode 110 always outputs composite and mode 111 always outputs component, whatever the switches do.
- R10: With a polarity bit of 0, the switch is active while its input is low. With a polarity bit of 1, it is active while the input is high.
- R11: With an edge bit of 1, the switch is captured on the falling clock edge. With an edge bit of 0, it is captured on the rising edge.
- R12: When `narrow_fmt` is 0, the overlay is never output. Each overlay choice falls back to the source the mode would use with the overlay switch inactive.
- R13: `src_id` encodes 0 = composite, 1 = component, 2 = analog-RGB, 3 = overlay. `pix_out` carries the chosen stream. The overlay pixel is `ovl_color` zero-extended to `PIX_W` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr_data | input | 8 | Control word to stage |
| ctrl_wr_en | input | 1 | Loads the pending control word |
| frame_start | input | 1 | Moves the pending word into the active word |
| narrow_fmt | input | 1 | 1 = narrow output format, overlay allowed |
| sw_rgb | input | 1 | Fast switch for the analog-RGB path |
| sw_ovl | input | 1 | Fast switch for the digital overlay |
| pix_comp | input | PIX_W | Composite pixel stream |
| pix_cpnt | input | PIX_W | Component pixel stream |
| pix_rgb | input | PIX_W | Analog-RGB path pixel stream |
| ovl_color | input | 3 | Digital overlay colour code |
| pix_out | output | PIX_W | Selected pixel |
| src_id | output | 2 | Identifier of the selected source |

## Verification
A wrong active control word or a wrong captured switch level shows up as a wrong `src_id`, together with a pixel value from the wrong stream. It appears on the second rising edge after the inputs that exposed it, and it stays there for as long as those inputs are held. A staging fault is seen as a mode change at the wrong moment: before `frame_start` when the write leaks through, or never when the transfer is lost. The bench places distinct constants on the four streams, so any wrong source is visible in `pix_out` as well as in `src_id`. It also moves a switch for half a cycle, so an edge-select fault produces a one-cycle glitch at exactly that point.

// File: rtl/fsw_pkg.sv
package fsw_pkg;

    localparam int NUM_SW   = 2;
    localparam int SW_RGB   = 0;
    localparam int SW_OVL   = 1;
    localparam int NUM_SRC  = 4;
    localparam int SRC_W    = $clog2(NUM_SRC);
    localparam logic [7:0] CTRL_RESET = 8'hCC;

    typedef enum logic [2:0] {
        MODE_COMP_RGB   = 3'b000,
        MODE_COMP_OVL   = 3'b001,
        MODE_CPNT_OVL   = 3'b010,
        MODE_OVL_TOP    = 3'b011,
        MODE_RGB_TOP    = 3'b100,
        MODE_COMP_TOP   = 3'b101,
        MODE_COMP_ONLY  = 3'b110,
        MODE_CPNT_ONLY  = 3'b111
    } mode_e;

    typedef enum logic [SRC_W-1:0] {
        SRC_COMP = 2'd0,
        SRC_CPNT = 2'd1,
        SRC_RGB  = 2'd2,
        SRC_OVL  = 2'd3
    } src_e;

    // Bit positions are fixed by the control word layout.
    typedef struct packed {
        mode_e mode;
        logic  rsvd;
        logic  edge_ovl;
        logic  edge_rgb;
        logic  pol_ovl;
        logic  pol_rgb;
    } ctrl_t;

    // A switch is active when its level equals its polarity bit.
    function automatic logic sw_active(input logic level, input logic pol);
        return ~(level ^ pol);
    endfunction

    // ovl_ok is the overlay switch already gated by the output format.
    function automatic src_e pick_src(input mode_e mode,
                                      input logic  rgb_ok,
                                      input logic  ovl_ok);
        src_e s;
        case (mode)
            MODE_COMP_RGB:  s = rgb_ok ? SRC_RGB : SRC_COMP;
            MODE_COMP_OVL:  s = ovl_ok ? SRC_OVL : SRC_COMP;
            MODE_CPNT_OVL:  s = ovl_ok ? SRC_OVL : SRC_CPNT;
            MODE_OVL_TOP:   s = ovl_ok ? SRC_OVL : (rgb_ok ? SRC_RGB : SRC_COMP);
            MODE_RGB_TOP:   s = rgb_ok ? SRC_RGB : (ovl_ok ? SRC_OVL : SRC_COMP);
            MODE_COMP_TOP:  s = !rgb_ok ? SRC_COMP : (ovl_ok ? SRC_OVL : SRC_RGB);
            MODE_CPNT_ONLY: s = SRC_CPNT;
            default:        s = SRC_COMP;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/fsw_ctrl_stage.sv
module fsw_ctrl_stage
    import fsw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  wr_data,
    input  logic        wr_en,
    input  logic        frame_start,
    output ctrl_t       act_ctrl
);
    ctrl_t pend_q;
    ctrl_t act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= ctrl_t'(CTRL_RESET);
            act_q  <= ctrl_t'(CTRL_RESET);
        end else begin
            if (wr_en)
                pend_q <= ctrl_t'(wr_data);
            if (frame_start)
                act_q <= pend_q;
        end
    end

    assign act_ctrl = act_q;
endmodule

// File: rtl/fsw_switch_capture.sv
module fsw_switch_capture (
    input  logic clk,
    input  logic rst,
    input  logic sw_in,
    input  logic on_fall,
    output logic sw_q
);
    logic fall_q;

    always_ff @(negedge clk) begin
        if (rst) fall_q <= 1'b0;
        else     fall_q <= sw_in;
    end

    // Both edge choices arrive in the rising-edge domain with the same latency.
    always_ff @(posedge clk) begin
        if (rst) sw_q <= 1'b0;
        else     sw_q <= on_fall ? fall_q : sw_in;
    end
endmodule

// File: rtl/fsw_pixel_select.sv
module fsw_pixel_select
    import fsw_pkg::*;
#(
    parameter int PIX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  mode_e            mode,
    input  logic             pol_rgb,
    input  logic             pol_ovl,
    input  logic             sw_rgb_q,
    input  logic             sw_ovl_q,
    input  logic             narrow_fmt,
    input  logic [PIX_W-1:0] pix_comp,
    input  logic [PIX_W-1:0] pix_cpnt,
    input  logic [PIX_W-1:0] pix_rgb,
    input  logic [2:0]       ovl_color,
    output logic [PIX_W-1:0] pix_out,
    output logic [SRC_W-1:0] src_id
);
    logic [PIX_W-1:0] in_pix [NUM_SRC];
    logic [PIX_W-1:0] stg_q  [NUM_SRC];
    logic             narrow_q;
    logic             rgb_ok;
    logic             ovl_ok;
    src_e             sel;

    assign in_pix[SRC_COMP] = pix_comp;
    assign in_pix[SRC_CPNT] = pix_cpnt;
    assign in_pix[SRC_RGB]  = pix_rgb;
    assign in_pix[SRC_OVL]  = PIX_W'(ovl_color);

    // Stage A: align the pixels with the captured switch levels.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg_q[g] <= '0;
            else     stg_q[g] <= in_pix[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) narrow_q <= 1'b0;
        else     narrow_q <= narrow_fmt;
    end

    always_comb begin
        rgb_ok = sw_active(sw_rgb_q, pol_rgb);
        ovl_ok = sw_active(sw_ovl_q, pol_ovl) & narrow_q;
        sel    = pick_src(mode, rgb_ok, ovl_ok);
    end

    // Stage B: pixel and identifier are registered together.
    always_ff @(posedge clk) begin
        if (rst) begin
            pix_out <= '0;
            src_id  <= SRC_COMP;
        end else begin
            pix_out <= stg_q[sel];
            src_id  <= sel;
        end
    end
endmodule

// File: rtl/fsw_overlay_mixer.sv
module fsw_overlay_mixer
    import fsw_pkg::*;
#(
    parameter int PIX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       ctrl_wr_data,
    input  logic             ctrl_wr_en,
    input  logic             frame_start,
    input  logic             narrow_fmt,
    input  logic             sw_rgb,
    input  logic             sw_ovl,
    input  logic [PIX_W-1:0] pix_comp,
    input  logic [PIX_W-1:0] pix_cpnt,
    input  logic [PIX_W-1:0] pix_rgb,
    input  logic [2:0]       ovl_color,
    output logic [PIX_W-1:0] pix_out,
    output logic [1:0]       src_id
);
    ctrl_t             act_ctrl;
    logic [NUM_SW-1:0] sw_raw;
    logic [NUM_SW-1:0] sw_fall;
    logic [NUM_SW-1:0] sw_cap;

    fsw_ctrl_stage u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .wr_data     (ctrl_wr_data),
        .wr_en       (ctrl_wr_en),
        .frame_start (frame_start),
        .act_ctrl    (act_ctrl)
    );

    assign sw_raw[SW_RGB]  = sw_rgb;
    assign sw_raw[SW_OVL]  = sw_ovl;
    assign sw_fall[SW_RGB] = act_ctrl.edge_rgb;
    assign sw_fall[SW_OVL] = act_ctrl.edge_ovl;

    for (genvar g = 0; g < NUM_SW; g++) begin : g_sw
        fsw_switch_capture u_cap (
            .clk     (clk),
            .rst     (rst),
            .sw_in   (sw_raw[g]),
            .on_fall (sw_fall[g]),
            .sw_q    (sw_cap[g])
        );
    end

    fsw_pixel_select #(.PIX_W(PIX_W)) u_sel (
        .clk        (clk),
        .rst        (rst),
        .mode       (act_ctrl.mode),
        .pol_rgb    (act_ctrl.pol_rgb),
        .pol_ovl    (act_ctrl.pol_ovl),
        .sw_rgb_q   (sw_cap[SW_RGB]),
        .sw_ovl_q   (sw_cap[SW_OVL]),
        .narrow_fmt (narrow_fmt),
        .pix_comp   (pix_comp),
        .pix_cpnt   (pix_cpnt),
        .pix_rgb    (pix_rgb),
        .ovl_color  (ovl_color),
        .pix_out    (pix_out),
        .src_id     (src_id)
    );
endmodule

// File: rtl/fsw_overlay_mixer_sva.sv
module fsw_overlay_mixer_sva #(
    parameter int PIX_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             frame_start,
    input logic             narrow_fmt,
    input logic [PIX_W-1:0] pix_comp,
    input logic [PIX_W-1:0] pix_cpnt,
    input logic [PIX_W-1:0] pix_out,
    input logic [1:0]       src_id,
    input logic [7:0]       act_bits
);
    logic [1:0] warm;

    always_ff @(posedge clk) begin
        if (rst)              warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    assert_reset_out_R1: assert property (@(posedge clk)
        $past(rst) |-> (pix_out == '0 && src_id == 2'd0));

    assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd1 && !$past(frame_start)) |-> $stable(act_bits));

    assert_mode0_sources_R4: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd1 && $past(act_bits[7:5]) == 3'b000) |-> (src_id == 2'd0 || src_id == 2'd2));

    assert_comp_only_R9: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd1 && $past(act_bits[7:5]) == 3'b110) |-> src_id == 2'd0);

    assert_cpnt_only_R9: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd1 && $past(act_bits[7:5]) == 3'b111) |-> src_id == 2'd1);

    assert_wide_no_ovl_R12: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd2 && !$past(narrow_fmt, 2)) |-> src_id != 2'd3);

    assert_comp_pixel_R2: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd2 && src_id == 2'd0) |-> pix_out == $past(pix_comp, 2));

    assert_cpnt_pixel_R13: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd2 && src_id == 2'd1) |-> pix_out == $past(pix_cpnt, 2));
endmodule

bind fsw_overlay_mixer fsw_overlay_mixer_sva #(.PIX_W(PIX_W)) u_sva (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .narrow_fmt  (narrow_fmt),
    .pix_comp    (pix_comp),
    .pix_cpnt    (pix_cpnt),
    .pix_out     (pix_out),
    .src_id      (src_id),
    .act_bits    (act_ctrl)
);

// File: tb/fsw_overlay_mixer_tb_top.sv
`timescale 1ns/1ps
module fsw_overlay_mixer_tb_top;
    localparam int PIX_W = 10;
    localparam int HALF  = 10;
    localparam logic [PIX_W-1:0] V_COMP = 10'h111;
    localparam logic [PIX_W-1:0] V_CPNT = 10'h222;
    localparam logic [PIX_W-1:0] V_RGB  = 10'h333;
    localparam logic [2:0]       V_COL  = 3'd5;

    // Vector: [12:5] ctrl, [4] narrow, [3] sw_rgb, [2] sw_ovl, [1:0] expected src.
    // Src ids: 0 composite, 1 component, 2 analog-RGB, 3 overlay.
    localparam int NV = 27;
    localparam logic [12:0] VEC [NV] = '{
        {8'h0C, 1'b1, 1'b0, 1'b0, 2'd2},   // R4 active-low rgb switch
        {8'h0C, 1'b1, 1'b1, 1'b0, 2'd0},   // R4
        {8'h2C, 1'b1, 1'b0, 1'b0, 2'd3},   // R5
        {8'h2C, 1'b1, 1'b0, 1'b1, 2'd0},   // R5
        {8'h2C, 1'b0, 1'b0, 1'b0, 2'd0},   // R12
        {8'h4C, 1'b1, 1'b1, 1'b0, 2'd3},   // R5
        {8'h4C, 1'b1, 1'b1, 1'b1, 2'd1},   // R5
        {8'h4C, 1'b0, 1'b1, 1'b0, 2'd1},   // R12
        {8'h6C, 1'b1, 1'b1, 1'b0, 2'd3},   // R6
        {8'h6C, 1'b1, 1'b0, 1'b0, 2'd3},   // R6
        {8'h6C, 1'b1, 1'b0, 1'b1, 2'd2},   // R6
        {8'h6C, 1'b1, 1'b1, 1'b1, 2'd0},   // R6
        {8'h6C, 1'b0, 1'b0, 1'b0, 2'd2},   // R12
        {8'h8C, 1'b1, 1'b0, 1'b0, 2'd2},   // R7
        {8'h8C, 1'b1, 1'b1, 1'b0, 2'd3},   // R7
        {8'h8C, 1'b1, 1'b1, 1'b1, 2'd0},   // R7
        {8'h8C, 1'b0, 1'b1, 1'b0, 2'd0},   // R12
        {8'hAC, 1'b1, 1'b1, 1'b0, 2'd0},   // R8
        {8'hAC, 1'b1, 1'b0, 1'b0, 2'd3},   // R8
        {8'hAC, 1'b1, 1'b0, 1'b1, 2'd2},   // R8
        {8'hAC, 1'b0, 1'b0, 1'b0, 2'd2},   // R12
        {8'hCC, 1'b1, 1'b0, 1'b0, 2'd0},   // R9
        {8'hEC, 1'b1, 1'b0, 1'b0, 2'd1},   // R9
        {8'h6F, 1'b1, 1'b1, 1'b1, 2'd3},   // R10 active-high
        {8'h6F, 1'b1, 1'b1, 1'b0, 2'd2},   // R10
        {8'h6F, 1'b1, 1'b0, 1'b0, 2'd0},   // R10
        {8'h60, 1'b1, 1'b0, 1'b0, 2'd3}    // R11 rising-edge capture, steady input
    };

    logic             clk = 1'b0;
    logic             rst;
    logic [7:0]       ctrl_wr_data;
    logic             ctrl_wr_en, frame_start, narrow_fmt, sw_rgb, sw_ovl;
    logic [PIX_W-1:0] pix_comp, pix_cpnt, pix_rgb;
    logic [2:0]       ovl_color;
    logic [PIX_W-1:0] pix_out;
    logic [1:0]       src_id;
    int               checks = 0;
    int               failures = 0;
    bit               done = 0;

    always #HALF clk = ~clk;

    fsw_overlay_mixer #(.PIX_W(PIX_W)) dut_i (
        .clk(clk), .rst(rst), .ctrl_wr_data(ctrl_wr_data), .ctrl_wr_en(ctrl_wr_en),
        .frame_start(frame_start), .narrow_fmt(narrow_fmt), .sw_rgb(sw_rgb),
        .sw_ovl(sw_ovl), .pix_comp(pix_comp), .pix_cpnt(pix_cpnt), .pix_rgb(pix_rgb),
        .ovl_color(ovl_color), .pix_out(pix_out), .src_id(src_id)
    );

    function automatic logic [PIX_W-1:0] exp_pix(input logic [1:0] s);
        case (s)
            2'd0:    return pix_comp;
            2'd1:    return V_CPNT;
            2'd2:    return V_RGB;
            default: return PIX_W'(V_COL);
        endcase
    endfunction

    task automatic check(input string req, input logic [1:0] es, input logic [PIX_W-1:0] ep);
        checks++;
        if (src_id !== es || pix_out !== ep) begin
            failures++;
            $display("FAIL %s: src_id=%0d pix_out=%h expected src_id=%0d pix_out=%h",
                     req, src_id, pix_out, es, ep);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic load_ctrl(input logic [7:0] c);
        ctrl_wr_data = c; ctrl_wr_en = 1'b1;
        tick(1);
        ctrl_wr_en = 1'b0; frame_start = 1'b1;
        tick(1);
        frame_start = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog: run did not complete");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ctrl_wr_data = 8'h00; ctrl_wr_en = 1'b0; frame_start = 1'b0;
        narrow_fmt = 1'b1; sw_rgb = 1'b0; sw_ovl = 1'b0;
        pix_comp = V_COMP; pix_cpnt = V_CPNT; pix_rgb = V_RGB; ovl_color = V_COL;
        tick(3);
        check("R1 in reset", 2'd0, '0);
        rst = 1'b0;
        tick(3);
        check("R1 default composite", 2'd0, V_COMP);
        sw_rgb = 1'b1; sw_ovl = 1'b1;
        tick(3);
        check("R1 default ignores switches", 2'd0, V_COMP);

        // R3: a write without frame_start leaves the mode unchanged
        sw_rgb = 1'b0; sw_ovl = 1'b0;
        ctrl_wr_data = 8'hEC; ctrl_wr_en = 1'b1;
        tick(1);
        ctrl_wr_en = 1'b0;
        tick(4);
        check("R3 write held before frame_start", 2'd0, V_COMP);
        frame_start = 1'b1;
        tick(1);
        frame_start = 1'b0;
        tick(2);
        check("R3 applied at frame_start", 2'd1, V_CPNT);

        for (int i = 0; i < NV; i++) begin
            load_ctrl(VEC[i][12:5]);
            narrow_fmt = VEC[i][4]; sw_rgb = VEC[i][3]; sw_ovl = VEC[i][2];
            tick(3);
            check($sformatf("R13 vector %0d ctrl=%h", i, VEC[i][12:5]),
                  VEC[i][1:0], exp_pix(VEC[i][1:0]));
        end
        narrow_fmt = 1'b1;

        // R2: two-edge latency, composite-only mode
        load_ctrl(8'hCC);
        tick(2);
        pix_comp = 10'h0A5;
        tick(1);
        check("R2 old pixel after one edge", 2'd0, V_COMP);
        tick(1);
        check("R2 new pixel after two edges", 2'd0, 10'h0A5);
        pix_comp = V_COMP;

        // R11: rgb switch low only in the first half of one cycle (mode 000, active low)
        for (int e = 0; e < 2; e++) begin
            load_ctrl(e == 0 ? 8'h0C : 8'h08);
            sw_rgb = 1'b1; sw_ovl = 1'b1;
            tick(3);
            sw_rgb = 1'b0;
            @(negedge clk); #1;
            sw_rgb = 1'b1;
            tick(2);
            if (e == 0) check("R11 falling-edge capture sees low", 2'd2, V_RGB);
            else        check("R11 rising-edge capture misses low", 2'd0, V_COMP);
            tick(1);
            check("R11 back to composite", 2'd0, V_COMP);
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule